// File: doc/BRIEF.md
# 4B5B Receive Stream Deframer

This block turns a serial stream of received 5-bit code groups into the nibble-wide receive interface of a 100BASE-X physical layer. One code bit arrives per cycle, qualified by `bit_vld`. While idle, the block hunts for the start-of-stream delimiter: the J group followed by the K group. It may find that pair at any bit offset, and the position of the match fixes the 5-bit group boundary for the rest of the stream.

Inside a stream, each complete group is decoded through the inverse 4B5B data table. The result is presented on `rxd` with `rx_dv` high and a one-cycle `nib_stb` pulse, which stands for the receive nibble clock. A T group followed by an R group ends the stream cleanly. Any other irregularity is a signal error: the block pulses `rx_er`, drops `rx_dv` and returns to hunting. The block only moves nibbles and has no knowledge of frame structure.

Control lives in a three-state machine. `ST_HUNT` searches for the delimiter and moves to `ST_DATA` on a match. `ST_DATA` stays in place on data groups, moves to `ST_END` on T, and returns to `ST_HUNT` on an error. `ST_END` returns to `ST_HUNT` on the next group: cleanly when that group is R, with an error otherwise.

Top module: `rx4b_deframer`

## Requirements
- R1: While `rst_n` is low, and after reset, `nib_stb`, `rx_dv`, `rx_er` and `rxd` are all 0 and the block is hunting.
- R2: While hunting, the block compares the last ten valid bits (the earliest bit most significant) against 1100010001 (J=11000, then K=10001), at every bit offset. A match fixes the group boundary, and the J and K groups produce no strobe.
- R3: In a stream, each data group is decoded as follows: 11110=0, 01001=1, 10100=2, 10101=3, 01010=4, 01011=5, 01110=6, 01111=7, 10010=8, 10011=9, 10110=A, 10111=B, 11010=C, 11011=D, 11100=E, 11101=F. Each group bit is listed first-received leftmost, and rxd[0] is the least significant data bit. `nib_stb` pulses for one cycle, in the cycle after the clock edge that takes the fifth bit, with `rx_dv`=1 and the decoded value on `rxd`.
- R4: `rxd` and `rx_dv` change only in cycles where `nib_stb` is high, and otherwise hold their values.
- R5: A T group (01101) produces no strobe and leaves `rx_dv` high. If the next group is R (00111), there is a strobe with `rx_dv`=0, `rx_er`=0 and `rxd`=0, and the block returns to hunting.
- R6: In a stream, a signal error is any one of: a group outside the data table, T and R; IDLE (11111); J or K; R without a preceding T; or any group after T other than R. A signal error gives a strobe with `rx_er`=1 for that one cycle, `rx_dv`=0 and `rxd`=0, and the block returns to hunting.
- R7: While hunting, bits that do not complete the delimiter produce no strobe, and `rx_dv` stays 0.
- R8: Cycles with `bit_vld` low are ignored. They neither shift the window nor advance the group count.
- R9: `rx_er` is high only together with `nib_stb`, and `rxd` is 0 whenever `rx_dv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Received code bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| nib_stb | output | 1 | One-cycle nibble timing strobe |
| rxd | output | 4 | Decoded receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error pulse |

## Verification
The stream is preceded by two stray bits, so a deframer that assumes the delimiter starts on a 5-bit boundary decodes every nibble from the wrong bits and fails all sixteen table entries. Separate streams end in IDLE, in a bad code, in a J inside the stream, and in T followed by a data group. A design that ignored any of these would keep `rx_dv` high or omit the `rx_er` pulse. A data-like group sent while hunting, and gaps in `bit_vld` inside a stream, catch a deframer that emits nibbles outside a stream or that counts unqualified cycles. A reset in mid-stream catches state that outlives reset.

// File: rtl/rx4b_pkg.sv
package rx4b_pkg;

    localparam int GW = 5;          // code group width
    localparam int NW = 4;          // nibble width
    localparam int WW = 2 * GW;     // delimiter window width

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_DATA,
        ST_END
    } rx_state_t;

    typedef enum logic [2:0] {
        GK_DATA,
        GK_IDLE,
        GK_TERM,
        GK_RST,
        GK_BAD
    } grp_kind_t;

    localparam logic [WW-1:0] SSD_PAT = 10'b11000_10001;
    localparam logic [GW-1:0] CG_IDLE = 5'b11111;
    localparam logic [GW-1:0] CG_TERM = 5'b01101;
    localparam logic [GW-1:0] CG_RST  = 5'b00111;

endpackage

// File: rtl/rx4b_window.sv
module rx4b_window #(
    parameter int              W   = 10,
    parameter logic [W-1:0]    PAT = '0,
    parameter int              TW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          clear,
    input  logic          bit_in,
    output logic          hit,
    output logic [TW-1:0] tail
);

    logic [W-1:0] win_q;
    logic [W-1:0] win_nxt;

    assign win_nxt = {win_q[W-2:0], bit_in};
    assign hit     = shift_en && (win_nxt == PAT);
    assign tail    = win_q[TW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (clear) begin
            win_q <= '0;
        end else if (shift_en) begin
            win_q <= win_nxt;
        end
    end

endmodule

// File: rtl/rx4b_grp_count.sv
module rx4b_grp_count #(
    parameter int GW = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    output logic last
);

    localparam int CW = (GW > 1) ? $clog2(GW) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(GW - 1);

    logic [CW-1:0] cnt_q;

    assign last = step && (cnt_q == LAST_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rx4b_grp_decode.sv
module rx4b_grp_decode
    import rx4b_pkg::*;
(
    input  logic [GW-1:0] grp,
    output grp_kind_t     kind,
    output logic [NW-1:0] nib
);

    always_comb begin
        kind = GK_DATA;
        nib  = '0;
        unique case (grp)
            5'b11110: nib = 4'h0;
            5'b01001: nib = 4'h1;
            5'b10100: nib = 4'h2;
            5'b10101: nib = 4'h3;
            5'b01010: nib = 4'h4;
            5'b01011: nib = 4'h5;
            5'b01110: nib = 4'h6;
            5'b01111: nib = 4'h7;
            5'b10010: nib = 4'h8;
            5'b10011: nib = 4'h9;
            5'b10110: nib = 4'hA;
            5'b10111: nib = 4'hB;
            5'b11010: nib = 4'hC;
            5'b11011: nib = 4'hD;
            5'b11100: nib = 4'hE;
            5'b11101: nib = 4'hF;
            CG_IDLE:  kind = GK_IDLE;
            CG_TERM:  kind = GK_TERM;
            CG_RST:   kind = GK_RST;
            default:  kind = GK_BAD;
        endcase
    end

endmodule

// File: rtl/rx4b_deframer.sv
module rx4b_deframer
    import rx4b_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_in,
    input  logic          bit_vld,
    output logic          nib_stb,
    output logic [NW-1:0] rxd,
    output logic          rx_dv,
    output logic          rx_er
);

    rx_state_t     state_q, state_d;
    logic          ssd_hit, win_hit;
    logic [GW-2:0] win_tail;
    logic          grp_done;
    logic          cnt_restart;
    logic          win_clear;
    logic [GW-1:0] grp_word;
    grp_kind_t     grp_kind;
    logic [NW-1:0] grp_nib;

    logic          emit;
    logic          emit_dv;
    logic          emit_er;
    logic [NW-1:0] emit_nib;

    rx4b_window #(
        .W   (WW),
        .PAT (SSD_PAT),
        .TW  (GW - 1)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_vld),
        .clear    (win_clear),
        .bit_in   (bit_in),
        .hit      (win_hit),
        .tail     (win_tail)
    );

    rx4b_grp_count #(
        .GW (GW)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cnt_restart),
        .step    (bit_vld && (state_q != ST_HUNT)),
        .last    (grp_done)
    );

    assign grp_word = {win_tail, bit_in};
    assign ssd_hit  = win_hit && (state_q == ST_HUNT);

    rx4b_grp_decode u_decode (
        .grp  (grp_word),
        .kind (grp_kind),
        .nib  (grp_nib)
    );

    // next state and emitted nibble
    always_comb begin
        state_d     = state_q;
        emit        = 1'b0;
        emit_dv     = 1'b0;
        emit_er     = 1'b0;
        emit_nib    = '0;
        cnt_restart = 1'b0;
        win_clear   = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (ssd_hit) begin
                    state_d     = ST_DATA;
                    cnt_restart = 1'b1;
                end
            end
            ST_DATA: begin
                if (grp_done) begin
                    unique case (grp_kind)
                        GK_DATA: begin
                            emit     = 1'b1;
                            emit_dv  = 1'b1;
                            emit_nib = grp_nib;
                        end
                        GK_TERM: begin
                            state_d = ST_END;
                        end
                        default: begin
                            emit      = 1'b1;
                            emit_er   = 1'b1;
                            state_d   = ST_HUNT;
                            win_clear = 1'b1;
                        end
                    endcase
                end
            end
            ST_END: begin
                if (grp_done) begin
                    emit      = 1'b1;
                    emit_er   = (grp_kind != GK_RST);
                    state_d   = ST_HUNT;
                    win_clear = 1'b1;
                end
            end
            default: begin
                state_d = ST_HUNT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nib_stb <= 1'b0;
            rx_er   <= 1'b0;
            rx_dv   <= 1'b0;
            rxd     <= '0;
        end else begin
            nib_stb <= emit;
            rx_er   <= emit && emit_er;
            if (emit) begin
                rx_dv <= emit_dv;
                rxd   <= emit_nib;
            end
        end
    end

endmodule

// File: rtl/rx4b_deframer_chk.sv
module rx4b_deframer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_vld,
    input logic       nib_stb,
    input logic [3:0] rxd,
    input logic       rx_dv,
    input logic       rx_er
);

    a_r9_er_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> nib_stb);

    a_r6_er_drops_dv: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> !rx_dv);

    a_r4_hold_between_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !nib_stb |-> ($stable(rx_dv) && $stable(rxd)));

    a_r8_stb_after_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |-> $past(bit_vld));

    a_r9_rxd_zero_without_dv: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_dv |-> (rxd == 4'h0));

    a_r3_stb_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |=> !nib_stb);

endmodule

bind rx4b_deframer rx4b_deframer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .nib_stb (nib_stb),
    .rxd     (rxd),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er)
);

// File: tb/rx4b_deframer_bench.sv
module rx4b_deframer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_vld = 1'b0;
    logic       nib_stb;
    logic [3:0] rxd;
    logic       rx_dv;
    logic       rx_er;

    int checks = 0;
    int errors = 0;
    int stb_seen = 0;
    logic [3:0] cap_rxd;
    logic       cap_er;
    logic       cap_dv;

    always #2 clk = ~clk;   // 250 MHz

    rx4b_deframer u_rx4b_deframer (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .nib_stb (nib_stb),
        .rxd     (rxd),
        .rx_dv   (rx_dv),
        .rx_er   (rx_er)
    );

    // vector: [19:16] req, [15:13] len, [12:8] bits, [7] stb, [6] dv, [5] er, [3:0] rxd
    function automatic logic [19:0] mk(input int req, input int len, input logic [4:0] bits,
                                       input bit stb, input bit dv, input bit er,
                                       input logic [3:0] nib);
        return {4'(req), 3'(len), bits, stb, dv, er, 1'b0, nib};
    endfunction

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd5: return "R5";
            4'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    localparam int NV = 45;
    localparam logic [19:0] VEC [0:NV-1] = '{
        // R7 hunting noise, then a 2-bit offset before the delimiter (R2)
        mk(7, 5, 5'b11111, 0, 0, 0, 4'h0),
        mk(7, 2, 5'b00001, 0, 0, 0, 4'h0),
        mk(2, 5, 5'b11000, 0, 0, 0, 4'h0),
        mk(2, 5, 5'b10001, 0, 0, 0, 4'h0),
        // R3 full data table
        mk(3, 5, 5'b11110, 1, 1, 0, 4'h0),
        mk(3, 5, 5'b01001, 1, 1, 0, 4'h1),
        mk(3, 5, 5'b10100, 1, 1, 0, 4'h2),
        mk(3, 5, 5'b10101, 1, 1, 0, 4'h3),
        mk(3, 5, 5'b01010, 1, 1, 0, 4'h4),
        mk(3, 5, 5'b01011, 1, 1, 0, 4'h5),
        mk(3, 5, 5'b01110, 1, 1, 0, 4'h6),
        mk(3, 5, 5'b01111, 1, 1, 0, 4'h7),
        mk(3, 5, 5'b10010, 1, 1, 0, 4'h8),
        mk(3, 5, 5'b10011, 1, 1, 0, 4'h9),
        mk(3, 5, 5'b10110, 1, 1, 0, 4'hA),
        mk(3, 5, 5'b10111, 1, 1, 0, 4'hB),
        mk(3, 5, 5'b11010, 1, 1, 0, 4'hC),
        mk(3, 5, 5'b11011, 1, 1, 0, 4'hD),
        mk(3, 5, 5'b11100, 1, 1, 0, 4'hE),
        mk(3, 5, 5'b11101, 1, 1, 0, 4'hF),
        // R5 clean end
        mk(5, 5, 5'b01101, 0, 1, 0, 4'h0),
        mk(5, 5, 5'b00111, 1, 0, 0, 4'h0),
        // R6 IDLE inside stream
        mk(2, 5, 5'b11000, 0, 0, 0, 4'h0),
        mk(2, 5, 5'b10001, 0, 0, 0, 4'h0),
        mk(3, 5, 5'b10101, 1, 1, 0, 4'h3),
        mk(6, 5, 5'b11111, 1, 0, 1, 4'h0),
        // R7 data-like group while hunting
        mk(7, 5, 5'b01111, 0, 0, 0, 4'h0),
        // R6 invalid code
        mk(2, 5, 5'b11000, 0, 0, 0, 4'h0),
        mk(2, 5, 5'b10001, 0, 0, 0, 4'h0),
        mk(3, 5, 5'b10011, 1, 1, 0, 4'h9),
        mk(6, 5, 5'b00000, 1, 0, 1, 4'h0),
        // R6 T followed by data
        mk(2, 5, 5'b11000, 0, 0, 0, 4'h0),
        mk(2, 5, 5'b10001, 0, 0, 0, 4'h0),
        mk(3, 5, 5'b11010, 1, 1, 0, 4'hC),
        mk(5, 5, 5'b01101, 0, 1, 0, 4'h0),
        mk(6, 5, 5'b01001, 1, 0, 1, 4'h0),
        // R6 J inside stream
        mk(2, 5, 5'b11000, 0, 0, 0, 4'h0),
        mk(2, 5, 5'b10001, 0, 0, 0, 4'h0),
        mk(3, 5, 5'b11100, 1, 1, 0, 4'hE),
        mk(6, 5, 5'b11000, 1, 0, 1, 4'h0),
        // normal stream again
        mk(2, 5, 5'b11000, 0, 0, 0, 4'h0),
        mk(2, 5, 5'b10001, 0, 0, 0, 4'h0),
        mk(3, 5, 5'b01110, 1, 1, 0, 4'h6),
        mk(5, 5, 5'b01101, 0, 1, 0, 4'h0),
        mk(5, 5, 5'b00111, 1, 0, 0, 4'h0)
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic sample();
        if (nib_stb) begin
            stb_seen++;
            cap_rxd = rxd;
            cap_er  = rx_er;
            cap_dv  = rx_dv;
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        @(posedge clk);
        #1;
        sample();
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'b1;
        @(posedge clk);
        #1;
        sample();
    endtask

    task automatic send_group(input logic [4:0] g, input int gap);
        for (int i = 4; i >= 0; i--) begin
            send_bit(g[i]);
            for (int k = 0; k < gap; k++) idle_cycle();
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check(nib_stb == 1'b0 && rx_er == 1'b0, "R1", "stb/er in reset", {nib_stb, rx_er}, 0);
        check(rx_dv == 1'b0 && rxd == 4'h0, "R1", "dv/rxd in reset", {rx_dv, rxd}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_cycle();
        check(rx_dv == 1'b0 && nib_stb == 1'b0, "R1", "outputs after reset", {rx_dv, nib_stb}, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [19:0] e;
            int n0;
            int len;
            e   = VEC[v];
            len = int'(e[15:13]);
            n0  = stb_seen;
            for (int i = len - 1; i >= 0; i--) send_bit(e[8 + i]);
            check((stb_seen - n0) == int'(e[7]), req_name(e[19:16]), $sformatf("strobes vec %0d", v),
                  stb_seen - n0, int'(e[7]));
            check(rx_dv == e[6], req_name(e[19:16]), $sformatf("rx_dv vec %0d", v),
                  int'(rx_dv), int'(e[6]));
            if (e[7] && (stb_seen - n0) == 1) begin
                check(cap_er == e[5], req_name(e[19:16]), $sformatf("rx_er vec %0d", v),
                      int'(cap_er), int'(e[5]));
                check(cap_rxd == e[3:0], req_name(e[19:16]), $sformatf("rxd vec %0d", v),
                      int'(cap_rxd), int'(e[3:0]));
            end
        end
        idle_cycle();
        check(rx_er == 1'b0, "R6", "rx_er one cycle only", int'(rx_er), 0);

        // R8 gaps in bit_vld inside a stream
        begin
            int n0;
            n0 = stb_seen;
            send_group(5'b11000, 2);
            send_group(5'b10001, 3);
            check(stb_seen == n0, "R8", "no strobe over gapped delimiter", stb_seen - n0, 0);
            send_group(5'b01011, 2);
            check(stb_seen - n0 == 1, "R8", "one strobe for gapped group", stb_seen - n0, 1);
            check(cap_rxd == 4'h5 && cap_dv, "R8", "gapped group value", int'(cap_rxd), 5);
            // R4 held between strobes
            idle_cycle();
            idle_cycle();
            check(rx_dv == 1'b1 && rxd == 4'h5, "R4", "rxd/rx_dv held", {rx_dv, rxd}, 21);
        end

        // R1 reset in mid-stream, stream state must not survive
        begin
            int n0;
            send_group(5'b10100, 0);
            check(rxd == 4'h2 && rx_dv, "R3", "value before reset", int'(rxd), 2);
            @(negedge clk);
            rst_n   = 1'b0;
            bit_vld = 1'b0;
            @(posedge clk);
            #1;
            check(rx_dv == 1'b0 && rxd == 4'h0, "R1", "mid-stream reset clears", {rx_dv, rxd}, 0);
            @(negedge clk);
            rst_n = 1'b1;
            n0 = stb_seen;
            send_group(5'b10100, 0);
            send_group(5'b01010, 0);
            check(stb_seen == n0 && rx_dv == 1'b0, "R7", "hunting after reset", stb_seen - n0, 0);
            send_group(5'b11000, 0);
            send_group(5'b10001, 0);
            send_group(5'b01010, 0);
            check(stb_seen - n0 == 1 && cap_rxd == 4'h4, "R2", "relock after reset",
                  int'(cap_rxd), 4);
            send_group(5'b01101, 0);
            send_group(5'b00111, 0);
            check(rx_dv == 1'b0 && cap_er == 1'b0, "R5", "clean end after relock", int'(rx_dv), 0);
        end

        idle_cycle();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule